// File: doc/BRIEF.md
# First-Come Shared-Bus Arbiter

This block arbitrates one shared transfer bus among several masters and delivers each transfer to one of several slave ports. Every master owns a small descriptor queue. A descriptor names a destination port, a length in bus cycles and an identifying tag. While the bus is not carrying a transfer, each master with a non-empty queue raises a request. The request carries its master index and the length of its queue head.

The controller latches the earliest request it sees. If several requests appear in the same cycle, the lowest master index wins. The controller then waits a fixed number of arbitration cycles and broadcasts a one-cycle grant that carries the winner's index. Each master compares the broadcast index with its own. Only the matching master pops its queue head and drives that head onto the bus during the grant cycle. The bus then stays occupied for the length of the transfer plus one cycle.

Each slave port watches the bus for its own port ID. On a match it delays the tag by its own processing delay and then raises a one-cycle completion. A transfer that no slave claims is discarded and flagged.

Top module: `mbus_fcfs_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `bus_busy_o`, `grant_valid_o`, `xfer_valid_o`, `drop_err_o` and every bit of `slv_done_o` are 0, and every bit of `push_ready_o` is 1.
- R2: Each master queue holds `Q_DEPTH` descriptors. `push_ready_o[m]` is 0 while queue m is full. A push to a full queue is ignored and never appears on the bus.
- R3: A master requests only while `bus_busy_o` is 0. A descriptor that arrives while a transfer is in progress is granted in cycle E+2+ARB_CYCLES, where E is the last busy cycle.
- R4: The request latched first wins. A request that appears while arbitration is already counting does not displace the latched winner, even if its master index is lower.
- R5: Requests that appear in the same cycle are resolved in favour of the lowest master index.
- R6: A push sampled in cycle P, while the bus is idle and no arbitration is pending, produces its grant in cycle P+2+ARB_CYCLES.
- R7: `grant_valid_o` is high for exactly one cycle per transfer, and `grant_id_o` equals the winning master index.
- R8: In the grant cycle, `xfer_valid_o` is 1. `xfer_src_o` is the winner's index, and `xfer_dst_o`, `xfer_len_o` and `xfer_tag_o` are the winner's queue head.
- R9: `bus_busy_o` is 1 from the grant cycle G through cycle G+len and is 0 in cycle G+len+1.
- R10: Slave s (port IDs 2, 4 and 6 and delays 2, 3 and 5 cycles for s = 0, 1 and 2) accepts a transfer only when the destination equals its port ID. It then raises `slv_done_o[s]` in cycle G+delay, with the tag on `slv_tag_o[s*8 +: 8]`. The other slaves stay silent.
- R11: A transfer whose destination matches no slave port produces a one-cycle `drop_err_o` in cycle G+1 and no completion.
- R12: Descriptors from one master are transferred in the order they were pushed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| push_valid_i | input | N_MASTERS | Per-master descriptor push strobe |
| push_dst_i | input | N_MASTERS*3 | Destination port ID, one slice per master |
| push_len_i | input | N_MASTERS*4 | Transfer length in bus cycles, one slice per master |
| push_tag_i | input | N_MASTERS*8 | Descriptor tag, one slice per master |
| push_ready_o | output | N_MASTERS | Queue has room |
| bus_busy_o | output | 1 | Bus carries a transfer |
| grant_valid_o | output | 1 | Grant broadcast strobe |
| grant_id_o | output | ID_W | Index of the granted master |
| xfer_valid_o | output | 1 | Descriptor on the bus |
| xfer_src_o | output | ID_W | Index of the master driving the bus |
| xfer_dst_o | output | 3 | Destination of the descriptor on the bus |
| xfer_len_o | output | 4 | Length of the descriptor on the bus |
| xfer_tag_o | output | 8 | Tag of the descriptor on the bus |
| slv_done_o | output | N_SLAVES | Per-slave completion pulse |
| slv_tag_o | output | N_SLAVES*8 | Tag of the completing transfer, one slice per slave |
| drop_err_o | output | 1 | Transfer addressed no slave |

## Verification
Single descriptors sent to an idle bus, with different masters, lengths from 0 to 15 and destinations that hit each slave or miss them all, pin down the grant latency, the bus-occupancy window, the slave selection with its per-port delay, and the drop path. Two masters pushing in the same cycle separate the tie rule from arrival order. A lower-index master arriving one cycle after a higher-index one shows that the controller keeps the first arrival rather than re-evaluating priority when it grants. Filling one queue behind a long transfer from another master exercises the deferred request, the full-queue rejection and the in-order draining of that master's descriptors.

// File: rtl/mbus_pkg.sv
package mbus_pkg;
  localparam int DST_W = 3;
  localparam int LEN_W = 4;
  localparam int TAG_W = 8;

  typedef struct packed {
    logic [DST_W-1:0] dst;
    logic [LEN_W-1:0] len;
    logic [TAG_W-1:0] tag;
  } desc_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARB  = 2'd1,
    ST_BUSY = 2'd2
  } bus_st_e;
endpackage

// File: rtl/mbus_master_port.sv
module mbus_master_port
  import mbus_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int ID_W  = 2,
  parameter int MY_ID = 0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            push_valid_i,
  input  desc_t           push_desc_i,
  output logic            push_ready_o,
  input  logic            bus_busy_i,
  input  logic            grant_valid_i,
  input  logic [ID_W-1:0] grant_id_i,
  output logic            req_o,
  output desc_t           head_o,
  output logic            drive_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  desc_t          mem_q [DEPTH];
  logic [AW-1:0]  wptr_q, rptr_q;
  logic [AW:0]    cnt_q;
  logic           do_push, not_empty;

  assign not_empty    = (cnt_q != '0);
  assign push_ready_o = (cnt_q < (AW+1)'(DEPTH));
  assign do_push      = push_valid_i && push_ready_o;
  assign req_o        = not_empty && !bus_busy_i;
  // grant is broadcast; accept it only when the ID is ours
  assign drive_o      = grant_valid_i && (grant_id_i == ID_W'(MY_ID)) && not_empty;
  assign head_o       = mem_q[rptr_q];

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wptr_q] <= push_desc_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (do_push) wptr_q <= (wptr_q == AW'(DEPTH-1)) ? '0 : wptr_q + 1'b1;
      if (drive_o) rptr_q <= (rptr_q == AW'(DEPTH-1)) ? '0 : rptr_q + 1'b1;
      cnt_q <= cnt_q + (AW+1)'(do_push) - (AW+1)'(drive_o);
    end
  end
endmodule

// File: rtl/mbus_fcfs_ctrl.sv
module mbus_fcfs_ctrl
  import mbus_pkg::*;
#(
  parameter int N_MASTERS  = 4,
  parameter int ID_W       = 2,
  parameter int ARB_CYCLES = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_MASTERS-1:0] req_i,
  input  logic [LEN_W-1:0] head_len_i [N_MASTERS],
  output logic             bus_busy_o,
  output logic             grant_valid_o,
  output logic [ID_W-1:0]  grant_id_o
);
  localparam int AC_W = $clog2(ARB_CYCLES + 1);

  bus_st_e          st_q;
  logic [ID_W-1:0]  win_q, pick;
  logic [LEN_W-1:0] win_len_q, busy_cnt_q;
  logic [AC_W-1:0]  arb_cnt_q;
  logic             grant_q;

  // same-cycle arrivals: lowest index wins
  always_comb begin
    pick = '0;
    for (int i = N_MASTERS-1; i >= 0; i--) begin
      if (req_i[i]) pick = ID_W'(i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      win_q      <= '0;
      win_len_q  <= '0;
      busy_cnt_q <= '0;
      arb_cnt_q  <= '0;
      grant_q    <= 1'b0;
    end else begin
      grant_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (|req_i) begin
          win_q     <= pick;
          win_len_q <= head_len_i[pick];
          arb_cnt_q <= AC_W'(ARB_CYCLES - 1);
          st_q      <= ST_ARB;
        end
        ST_ARB: begin
          // later requests are ignored: the first arrival is kept
          if (arb_cnt_q == '0) begin
            st_q       <= ST_BUSY;
            busy_cnt_q <= win_len_q;
            grant_q    <= 1'b1;
          end else begin
            arb_cnt_q <= arb_cnt_q - 1'b1;
          end
        end
        ST_BUSY: begin
          if (busy_cnt_q == '0) st_q <= ST_IDLE;
          else busy_cnt_q <= busy_cnt_q - 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign bus_busy_o    = (st_q == ST_BUSY);
  assign grant_valid_o = grant_q;
  assign grant_id_o    = win_q;
endmodule

// File: rtl/mbus_slave_port.sv
module mbus_slave_port
  import mbus_pkg::*;
#(
  parameter int PORT_ID = 0,
  parameter int DELAY   = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             xfer_valid_i,
  input  logic [DST_W-1:0] xfer_dst_i,
  input  logic [TAG_W-1:0] xfer_tag_i,
  output logic             hit_o,
  output logic             done_o,
  output logic [TAG_W-1:0] done_tag_o
);
  logic [DELAY-1:0] vld_q;
  logic [TAG_W-1:0] tag_q [DELAY];

  assign hit_o = xfer_valid_i && (xfer_dst_i == DST_W'(PORT_ID));

  // delay line: overlapping accepts each complete after DELAY cycles
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      for (int i = 0; i < DELAY; i++) tag_q[i] <= '0;
    end else begin
      vld_q[0] <= hit_o;
      tag_q[0] <= xfer_tag_i;
      for (int i = 1; i < DELAY; i++) begin
        vld_q[i] <= vld_q[i-1];
        tag_q[i] <= tag_q[i-1];
      end
    end
  end

  assign done_o     = vld_q[DELAY-1];
  assign done_tag_o = tag_q[DELAY-1];
endmodule

// File: rtl/mbus_fcfs_top.sv
module mbus_fcfs_top
  import mbus_pkg::*;
#(
  parameter int N_MASTERS  = 4,
  parameter int Q_DEPTH    = 4,
  parameter int ARB_CYCLES = 1,
  parameter int N_SLAVES   = 3,
  parameter int DLY_W      = 4,
  parameter logic [N_SLAVES*DST_W-1:0] SLV_ID  = {3'd6, 3'd4, 3'd2},
  parameter logic [N_SLAVES*DLY_W-1:0] SLV_DLY = {4'd5, 4'd3, 4'd2},
  localparam int ID_W = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [N_MASTERS-1:0]       push_valid_i,
  input  logic [N_MASTERS*DST_W-1:0] push_dst_i,
  input  logic [N_MASTERS*LEN_W-1:0] push_len_i,
  input  logic [N_MASTERS*TAG_W-1:0] push_tag_i,
  output logic [N_MASTERS-1:0]       push_ready_o,
  output logic                      bus_busy_o,
  output logic                      grant_valid_o,
  output logic [ID_W-1:0]           grant_id_o,
  output logic                      xfer_valid_o,
  output logic [ID_W-1:0]           xfer_src_o,
  output logic [DST_W-1:0]          xfer_dst_o,
  output logic [LEN_W-1:0]          xfer_len_o,
  output logic [TAG_W-1:0]          xfer_tag_o,
  output logic [N_SLAVES-1:0]        slv_done_o,
  output logic [N_SLAVES*TAG_W-1:0]  slv_tag_o,
  output logic                      drop_err_o
);
  logic [N_MASTERS-1:0] req, drive;
  desc_t                head [N_MASTERS];
  logic [LEN_W-1:0]     head_len [N_MASTERS];
  logic [N_SLAVES-1:0]  hit;
  desc_t                xfer;
  logic                 drop_q;

  for (genvar m = 0; m < N_MASTERS; m++) begin : g_mst
    desc_t in_desc;
    assign in_desc.dst = push_dst_i[m*DST_W +: DST_W];
    assign in_desc.len = push_len_i[m*LEN_W +: LEN_W];
    assign in_desc.tag = push_tag_i[m*TAG_W +: TAG_W];
    assign head_len[m] = head[m].len;

    mbus_master_port #(.DEPTH(Q_DEPTH), .ID_W(ID_W), .MY_ID(m)) u_mst (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .push_valid_i (push_valid_i[m]),
      .push_desc_i  (in_desc),
      .push_ready_o (push_ready_o[m]),
      .bus_busy_i   (bus_busy_o),
      .grant_valid_i(grant_valid_o),
      .grant_id_i   (grant_id_o),
      .req_o        (req[m]),
      .head_o       (head[m]),
      .drive_o      (drive[m])
    );
  end

  mbus_fcfs_ctrl #(.N_MASTERS(N_MASTERS), .ID_W(ID_W), .ARB_CYCLES(ARB_CYCLES)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_i        (req),
    .head_len_i   (head_len),
    .bus_busy_o   (bus_busy_o),
    .grant_valid_o(grant_valid_o),
    .grant_id_o   (grant_id_o)
  );

  // bus mux: at most one master drives
  always_comb begin
    xfer       = '0;
    xfer_src_o = '0;
    for (int i = 0; i < N_MASTERS; i++) begin
      if (drive[i]) begin
        xfer       = head[i];
        xfer_src_o = ID_W'(i);
      end
    end
  end

  assign xfer_valid_o = |drive;
  assign xfer_dst_o   = xfer.dst;
  assign xfer_len_o   = xfer.len;
  assign xfer_tag_o   = xfer.tag;

  for (genvar s = 0; s < N_SLAVES; s++) begin : g_slv
    localparam int PID = int'(SLV_ID[s*DST_W +: DST_W]);
    localparam int DLY = int'(SLV_DLY[s*DLY_W +: DLY_W]);

    mbus_slave_port #(.PORT_ID(PID), .DELAY(DLY)) u_slv (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .xfer_valid_i(xfer_valid_o),
      .xfer_dst_i  (xfer.dst),
      .xfer_tag_i  (xfer.tag),
      .hit_o       (hit[s]),
      .done_o      (slv_done_o[s]),
      .done_tag_o  (slv_tag_o[s*TAG_W +: TAG_W])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) drop_q <= 1'b0;
    else         drop_q <= xfer_valid_o && (hit == '0);
  end

  assign drop_err_o = drop_q;
endmodule

// File: rtl/mbus_fcfs_chk.sv
module mbus_fcfs_chk #(
  parameter int ID_W = 2
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            bus_busy_o,
  input logic            grant_valid_o,
  input logic [ID_W-1:0] grant_id_o,
  input logic            xfer_valid_o,
  input logic [ID_W-1:0] xfer_src_o,
  input logic            drop_err_o
);
  // R7
  grant_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_valid_o |=> !grant_valid_o);

  // R8
  grant_drives_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_valid_o |-> (xfer_valid_o && xfer_src_o == grant_id_o));

  // R9
  grant_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_valid_o |-> bus_busy_o);

  // R3
  busy_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_busy_o) |-> grant_valid_o);

  // R3
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_busy_o |-> !xfer_valid_o);

  // R11
  drop_after_xfer_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_err_o |-> $past(xfer_valid_o));
endmodule

bind mbus_fcfs_top mbus_fcfs_chk #(.ID_W(ID_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .bus_busy_o   (bus_busy_o),
  .grant_valid_o(grant_valid_o),
  .grant_id_o   (grant_id_o),
  .xfer_valid_o (xfer_valid_o),
  .xfer_src_o   (xfer_src_o),
  .drop_err_o   (drop_err_o)
);

// File: tb/mbus_fcfs_top_tb_top.sv
module mbus_fcfs_top_tb_top;
  localparam int NM = 4;
  localparam int NS = 3;
  localparam int A  = 3;
  localparam int QD = 2;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [NM-1:0] push_valid_i = '0;
  logic [NM*3-1:0] push_dst_i = '0;
  logic [NM*4-1:0] push_len_i = '0;
  logic [NM*8-1:0] push_tag_i = '0;
  logic [NM-1:0] push_ready_o;
  logic          bus_busy_o, grant_valid_o, xfer_valid_o, drop_err_o;
  logic [1:0]    grant_id_o, xfer_src_o;
  logic [2:0]    xfer_dst_o;
  logic [3:0]    xfer_len_o;
  logic [7:0]    xfer_tag_o;
  logic [NS-1:0] slv_done_o;
  logic [NS*8-1:0] slv_tag_o;

  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;

  always #4 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  mbus_fcfs_top #(.N_MASTERS(NM), .Q_DEPTH(QD), .ARB_CYCLES(A), .N_SLAVES(NS)) dut_i (
    .clk_i, .rst_ni, .push_valid_i, .push_dst_i, .push_len_i, .push_tag_i,
    .push_ready_o, .bus_busy_o, .grant_valid_o, .grant_id_o, .xfer_valid_o,
    .xfer_src_o, .xfer_dst_o, .xfer_len_o, .xfer_tag_o, .slv_done_o,
    .slv_tag_o, .drop_err_o
  );

  typedef struct packed {
    logic [1:0] m;
    logic [2:0] dst;
    logic [3:0] len;
    logic [7:0] tag;
    logic [1:0] slv;
    logic       drop;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 3'd2, 4'd0,  8'h11, 2'd0, 1'b0},
    '{2'd3, 3'd6, 4'd5,  8'h22, 2'd2, 1'b0},
    '{2'd1, 3'd4, 4'd2,  8'h33, 2'd1, 1'b0},
    '{2'd2, 3'd7, 4'd1,  8'h44, 2'd0, 1'b1},
    '{2'd0, 3'd6, 4'd15, 8'h55, 2'd2, 1'b0},
    '{2'd2, 3'd3, 4'd3,  8'h66, 2'd0, 1'b1}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  function automatic int slv_delay(input int s);
    return (s == 0) ? 2 : (s == 1) ? 3 : 5;
  endfunction

  task automatic set_push(input int m, input int dst, input int len, input int tag);
    push_valid_i[m] = 1'b1;
    push_dst_i[m*3 +: 3] = 3'(dst);
    push_len_i[m*4 +: 4] = 4'(len);
    push_tag_i[m*8 +: 8] = 8'(tag);
  endtask

  task automatic wait_grant(input int limit, output int id, output int at, output int tag);
    id = -1; at = -1; tag = -1;
    for (int k = 0; k < limit; k++) begin
      @(negedge clk_i);
      if (grant_valid_o) begin
        id = int'(grant_id_o); at = cyc; tag = int'(xfer_tag_o);
        return;
      end
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    finish_run();
  end

  initial begin
    int id, g, tg, c, g1, g2;

    // R1 reset state
    repeat (3) @(negedge clk_i);
    chk(!bus_busy_o && !grant_valid_o && !xfer_valid_o && !drop_err_o && slv_done_o == '0,
        "R1 outputs idle in reset", 1, 0);
    chk(push_ready_o == 4'hF, "R1 ready in reset", int'(push_ready_o), 15);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!bus_busy_o && !grant_valid_o && !xfer_valid_o && !drop_err_o && slv_done_o == '0,
        "R1 outputs idle after reset", 1, 0);
    chk(push_ready_o == 4'hF, "R1 ready after reset", int'(push_ready_o), 15);

    // vector table: single descriptor onto an idle bus
    for (int v = 0; v < NV; v++) begin
      vec_t t;
      int kmax;
      t = VECS[v];
      @(negedge clk_i);
      set_push(int'(t.m), int'(t.dst), int'(t.len), int'(t.tag));
      c = cyc;
      @(negedge clk_i);
      push_valid_i = '0;
      wait_grant(40, id, g, tg);
      chk(g == c + 2 + A, "R6 grant latency", g - c, 2 + A);
      chk(id == int'(t.m), "R7 grant id", id, int'(t.m));
      chk(xfer_valid_o && int'(xfer_src_o) == int'(t.m), "R8 source on bus",
          int'(xfer_src_o), int'(t.m));
      chk(xfer_dst_o == t.dst && xfer_len_o == t.len, "R8 head on bus",
          int'({xfer_dst_o, xfer_len_o}), int'({t.dst, t.len}));
      chk(tg == int'(t.tag), "R8 tag on bus", tg, int'(t.tag));
      chk(bus_busy_o, "R9 busy in grant cycle", int'(bus_busy_o), 1);
      kmax = (int'(t.len) + 1 > 6) ? int'(t.len) + 1 : 6;
      for (int k = 1; k <= kmax; k++) begin
        int exp_done;
        @(negedge clk_i);
        chk(bus_busy_o == (k <= int'(t.len)), "R9 busy window", int'(bus_busy_o),
            int'(k <= int'(t.len)));
        if (k == 1) chk(!grant_valid_o, "R7 grant one cycle", int'(grant_valid_o), 0);
        exp_done = (!t.drop && k == slv_delay(int'(t.slv))) ? (1 << int'(t.slv)) : 0;
        if (t.drop)
          chk(int'(slv_done_o) == 0, "R11 no completion on drop", int'(slv_done_o), 0);
        else
          chk(int'(slv_done_o) == exp_done, "R10 slave done timing", int'(slv_done_o), exp_done);
        if (exp_done != 0)
          chk(slv_tag_o[int'(t.slv)*8 +: 8] == t.tag, "R10 slave tag",
              int'(slv_tag_o[int'(t.slv)*8 +: 8]), int'(t.tag));
        chk(drop_err_o == (t.drop && k == 1), "R11 drop pulse", int'(drop_err_o),
            int'(t.drop && k == 1));
      end
      repeat (2) @(negedge clk_i);
    end

    // R5 same-cycle requests: lowest index first
    @(negedge clk_i);
    set_push(3, 2, 1, 8'h71);
    set_push(1, 4, 2, 8'h72);
    c = cyc;
    @(negedge clk_i);
    push_valid_i = '0;
    wait_grant(40, id, g1, tg);
    chk(id == 1, "R5 tie lowest index", id, 1);
    chk(g1 == c + 2 + A, "R6 tie grant latency", g1 - c, 2 + A);
    wait_grant(40, id, g2, tg);
    chk(id == 3, "R5 tie second", id, 3);
    chk(g2 == g1 + 2 + 2 + A, "R3 deferred grant after busy", g2 - g1, 4 + A);
    repeat (10) @(negedge clk_i);

    // R4 first arrival kept over a later lower index
    @(negedge clk_i);
    set_push(2, 6, 1, 8'h81);
    c = cyc;
    @(negedge clk_i);
    push_valid_i = '0;
    set_push(0, 2, 0, 8'h82);
    @(negedge clk_i);
    push_valid_i = '0;
    wait_grant(40, id, g1, tg);
    chk(id == 2, "R4 first arrival wins", id, 2);
    chk(g1 == c + 2 + A, "R4 first grant time", g1 - c, 2 + A);
    wait_grant(40, id, g2, tg);
    chk(id == 0 && tg == 8'h82, "R4 later arrival next", id, 0);
    chk(g2 == g1 + 1 + 2 + A, "R3 later arrival waits busy", g2 - g1, 3 + A);
    repeat (10) @(negedge clk_i);

    // R2, R3, R12: fill master 0 behind a long transfer of master 1
    @(negedge clk_i);
    set_push(1, 2, 12, 8'hA0);
    @(negedge clk_i);
    push_valid_i = '0;
    wait_grant(40, id, g, tg);
    chk(id == 1, "R7 long transfer owner", id, 1);
    @(negedge clk_i);
    set_push(0, 4, 1, 8'hB1);
    @(negedge clk_i);
    set_push(0, 4, 1, 8'hB2);
    @(negedge clk_i);
    chk(push_ready_o[0] == 1'b0, "R2 ready low when full", int'(push_ready_o[0]), 0);
    chk(!grant_valid_o && bus_busy_o, "R3 no grant while busy", int'(grant_valid_o), 0);
    set_push(0, 4, 1, 8'hB3);
    @(negedge clk_i);
    push_valid_i = '0;
    wait_grant(40, id, g1, tg);
    chk(id == 0 && tg == 8'hB1, "R12 first pushed first", tg, 8'hB1);
    chk(g1 == g + 12 + 2 + A, "R3 grant after busy ends", g1 - g, 14 + A);
    wait_grant(40, id, g2, tg);
    chk(id == 0 && tg == 8'hB2, "R12 second pushed second", tg, 8'hB2);
    wait_grant(40, id, g2, tg);
    chk(id == -1, "R2 push to full queue ignored", id, -1);
    chk(push_ready_o == 4'hF, "R2 ready restored", int'(push_ready_o), 15);

    finish_run();
  end
endmodule